// File: doc/BRIEF.md
# Page Table Entry Permission Checker

This block judges a single 64-bit page table entry against one memory access. It looks at the entry's attribute byte and sorts it into one of three classes: invalid, a pointer to the next table level, or a leaf. It then decides whether the access is allowed, given four inputs:

- the access kind: instruction fetch, load, store, or atomic read-modify-write;
- the current privilege level;
- the make-executable-readable status bit;
- the supervisor-user-access status bit.

The block also reports two further results. It says whether the accessed and dirty flags in the entry must be written back, and it supplies the rewritten attribute byte. Given a failure kind from the surrounding table walker, it produces the architectural exception cause.

A table walker feeds entries in one per cycle with `in_valid`. With the default `REGISTER_OUT = 1`, every result appears one clock later, qualified by `out_valid`. With `REGISTER_OUT = 0`, the results follow the inputs combinationally. The physical page number field (bits 53:10) is passed out unchanged.

Top module: `pte_perm_check`

## Requirements
- R1: An entry is invalid when attribute bit 0 (valid) is 0, or when bit 2 (write) is 1 while bit 1 (read) is 0. A valid entry with bits 1, 2 and 3 (execute) all 0 is a pointer. Every other entry is a leaf. Exactly one of `is_invalid`, `is_pointer` and `is_leaf` is 1.
- R2: With access code 1 (load), the read condition is: bit 1 set, or bit 3 set with `mxr` high. With code 2 (store), the write condition is bit 2 set. With code 3 (atomic), both conditions must hold.
- R3: With access code 0 (fetch), bit 3 is required, and `mxr` has no effect on the result.
- R4: At privilege code 0 (user), every access kind also requires attribute bit 4 (user) to be set.
- R5: At privilege code 1 (supervisor), load, store and atomic accesses to a page with bit 4 set are granted only when `sum` is high. A fetch requires bit 4 to be clear, whatever the value of `sum`.
- R6: At privilege code 2 or 3, `priv_error` is 1 and `granted` is 0. At codes 0 and 1, `priv_error` is 0.
- R7: `upd_needed` is 1 when bit 6 (accessed) is 0, or when the access is a store or atomic and bit 7 (dirty) is 0. `upd_attr` equals the input byte with bit 6 set whenever an update is needed, and with bit 7 also set in the second case. When no update is needed, `upd_attr` equals the input byte.
- R8: `exc_cause` reflects `fail_kind`. Kind 0 means an entry memory access error; kinds 1 to 4 mean invalid entry, no permission, misaligned superpage, and update not enabled. For kind 0 the cause is an access fault: 1 for fetch, 5 for load, 7 for store and atomic. For any other kind it is a page fault: 12 for fetch, 13 for load, 15 for store and atomic.
- R9: With `REGISTER_OUT = 1`, `out_valid` and all results follow the inputs by exactly one clock cycle.
- R10: While `rst_n` is low, `out_valid` and every registered result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input entry is present |
| pte | input | 64 | Page table entry |
| access | input | 2 | 0 fetch, 1 load, 2 store, 3 atomic |
| priv | input | 2 | 0 user, 1 supervisor, 2 and 3 not allowed |
| mxr | input | 1 | Execute-only pages readable |
| sum | input | 1 | Supervisor may access user pages |
| fail_kind | input | 3 | Translation failure kind for cause mapping |
| out_valid | output | 1 | Results are valid |
| is_invalid | output | 1 | Entry is invalid |
| is_pointer | output | 1 | Entry points to the next level |
| is_leaf | output | 1 | Entry is a leaf |
| granted | output | 1 | Access is allowed |
| priv_error | output | 1 | Check requested at a privilege level that is not allowed |
| upd_needed | output | 1 | Accessed/dirty write-back is needed |
| upd_attr | output | 8 | Rewritten attribute byte |
| exc_cause | output | 4 | Exception cause code |
| ppn | output | 44 | Physical page number field |

## Verification
The assertions assume that `rst_n` is held low for at least one rising edge before traffic starts. They also assume that `in_valid` carries no X once reset is released. The properties are written only over the outputs, and they are qualified by `out_valid` so that idle cycles carry no obligation. The stimulus meets both assumptions: it drives every input to a known value before reset is released. It then changes inputs only one time unit after a rising edge, and it holds `in_valid` high through the sweep except during a directed idle window.

// File: rtl/pte_perm_check.sv
module pte_perm_check #(
  parameter bit REGISTER_OUT = 1'b1,
  parameter int PTE_W        = 64,
  parameter int PPN_LO       = 10,
  parameter int PPN_W        = 44,
  parameter int CAUSE_W      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [PTE_W-1:0]   pte,
  input  logic [1:0]         access,
  input  logic [1:0]         priv,
  input  logic               mxr,
  input  logic               sum,
  input  logic [2:0]         fail_kind,
  output logic               out_valid,
  output logic               is_invalid,
  output logic               is_pointer,
  output logic               is_leaf,
  output logic               granted,
  output logic               priv_error,
  output logic               upd_needed,
  output logic [7:0]         upd_attr,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [PPN_W-1:0]   ppn
);
  localparam int PPN_HI = PPN_LO + PPN_W - 1;
  localparam int OUT_W  = 6 + 8 + CAUSE_W + PPN_W;

  logic [7:0] attr;
  logic v, r, w, x, u, a, d;
  assign attr = pte[7:0];
  assign {d, a, u, x, w, r, v} = {attr[7:6], attr[4:0]};

  logic unused_bits;
  assign unused_bits = ^{pte[PTE_W-1:PPN_HI+1], pte[PPN_LO-1:8], attr[5]};

  logic bad, ptr, rd_ok, base_ok, mode_ok, perr, store, upd_d, upd;
  logic [CAUSE_W-1:0] cause;

  assign bad   = !v || (w && !r);
  assign ptr   = !bad && !r && !w && !x;
  assign rd_ok = r || (x && mxr);
  assign store = access[1];
  assign perr  = priv[1];

  always_comb begin
    case (access)
      2'd0:    base_ok = x;
      2'd1:    base_ok = rd_ok;
      2'd2:    base_ok = w;
      default: base_ok = w && rd_ok;
    endcase
    if (priv == 2'd0)
      mode_ok = u && base_ok;
    else if (access == 2'd0)
      mode_ok = !u && x;
    else
      mode_ok = (!u || sum) && base_ok;
  end

  assign upd_d = store && !d;
  assign upd   = !a || upd_d;

  always_comb begin
    case (access)
      2'd0:    cause = (fail_kind == 3'd0) ? CAUSE_W'(1) : CAUSE_W'(12);
      2'd1:    cause = (fail_kind == 3'd0) ? CAUSE_W'(5) : CAUSE_W'(13);
      default: cause = (fail_kind == 3'd0) ? CAUSE_W'(7) : CAUSE_W'(15);
    endcase
  end

  logic [OUT_W-1:0] nxt, cur;
  assign nxt = {bad, ptr, !bad && !ptr, mode_ok && !perr, perr, upd,
                attr | {upd_d, upd, 6'b0}, cause, pte[PPN_HI:PPN_LO]};

  generate
    if (REGISTER_OUT) begin : g_reg
      logic vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          cur   <= '0;
        end else begin
          vld_q <= in_valid;
          cur   <= nxt;
        end
      end
      assign out_valid = vld_q;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign cur        = nxt;
      assign out_valid  = in_valid;
    end
  endgenerate

  assign {is_invalid, is_pointer, is_leaf, granted, priv_error, upd_needed,
          upd_attr, exc_cause, ppn} = cur;
endmodule

// File: rtl/pte_perm_check_sva.sv
module pte_perm_check_sva #(
  parameter bit REGISTER_OUT = 1'b1,
  parameter int CAUSE_W      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               out_valid,
  input logic               is_invalid,
  input logic               is_pointer,
  input logic               is_leaf,
  input logic               granted,
  input logic               priv_error,
  input logic               upd_needed,
  input logic [7:0]         upd_attr,
  input logic [CAUSE_W-1:0] exc_cause
);
  p_one_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({is_invalid, is_pointer, is_leaf}) == 1);

  p_leaf_has_perm_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && granted |-> is_leaf || (upd_attr[3:1] != 3'b000 && !is_pointer));

  p_no_grant_on_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && priv_error |-> !granted);

  p_update_sets_accessed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && upd_needed |-> upd_attr[6]);

  p_cause_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (exc_cause == 1 || exc_cause == 5 || exc_cause == 7 ||
                   exc_cause == 12 || exc_cause == 13 || exc_cause == 15));

  generate
    if (REGISTER_OUT) begin : g_lat
      p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));
    end
  endgenerate
endmodule

bind pte_perm_check pte_perm_check_sva #(.REGISTER_OUT(REGISTER_OUT), .CAUSE_W(CAUSE_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .is_invalid(is_invalid), .is_pointer(is_pointer), .is_leaf(is_leaf),
  .granted(granted), .priv_error(priv_error), .upd_needed(upd_needed),
  .upd_attr(upd_attr), .exc_cause(exc_cause)
);

// File: tb/tb_pte_perm_check.sv
`timescale 1ns/1ps
module tb_pte_perm_check;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, mxr = 1'b0, sum = 1'b0;
  logic [63:0] pte = '0;
  logic [1:0] access = '0, priv = '0;
  logic [2:0] fail_kind = '0;
  logic out_valid, is_invalid, is_pointer, is_leaf, granted, priv_error, upd_needed;
  logic [7:0] upd_attr;
  logic [3:0] exc_cause;
  logic [43:0] ppn;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pte_perm_check dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pte(pte), .access(access),
    .priv(priv), .mxr(mxr), .sum(sum), .fail_kind(fail_kind),
    .out_valid(out_valid), .is_invalid(is_invalid), .is_pointer(is_pointer),
    .is_leaf(is_leaf), .granted(granted), .priv_error(priv_error),
    .upd_needed(upd_needed), .upd_attr(upd_attr), .exc_cause(exc_cause), .ppn(ppn)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [2:0] exp_class(input logic [7:0] t);
    logic bad;
    bad = !t[0] || (t[2] && !t[1]);
    if (bad) return 3'b100;
    if (t[3:1] == 3'b000) return 3'b010;
    return 3'b001;
  endfunction

  function automatic logic exp_grant(input logic [7:0] t, input logic [1:0] ac,
                                     input logic [1:0] pv, input logic mx, input logic sm);
    logic rd, wr, ex, ok;
    rd = t[1] | (t[3] & mx);
    wr = t[2];
    ex = t[3];
    ok = (ac == 0) ? ex : (ac == 1) ? rd : (ac == 2) ? wr : (rd & wr);
    if (pv >= 2) return 1'b0;
    if (pv == 0) return ok & t[4];
    if (ac == 0) return ex & ~t[4];
    return ok & (~t[4] | sm);
  endfunction

  function automatic logic [3:0] exp_cause(input logic [1:0] ac, input logic [2:0] fk);
    logic [3:0] acc_c, pg_c;
    acc_c = (ac == 0) ? 4'd1 : (ac == 1) ? 4'd5 : 4'd7;
    pg_c  = (ac == 0) ? 4'd12 : (ac == 1) ? 4'd13 : 4'd15;
    return (fk == 0) ? acc_c : pg_c;
  endfunction

  task automatic drive(input logic [7:0] t, input logic [1:0] ac, input logic [1:0] pv,
                       input logic mx, input logic sm, input logic [2:0] fk);
    pte = {10'h2A5, 32'hC0DE_0000 | 32'(t), 12'hA5B, 2'b11, t};
    access = ac; priv = pv; mxr = mx; sum = sm; fail_kind = fk; in_valid = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic full_check(input logic [7:0] t, input logic [1:0] ac, input logic [1:0] pv,
                            input logic mx, input logic sm, input logic [2:0] fk);
    logic upd_d, upd;
    string gtag;
    drive(t, ac, pv, mx, sm, fk);
    upd_d = ac[1] && !t[7];
    upd = !t[6] || upd_d;
    gtag = (pv == 0) ? "R4" : (pv == 1) ? "R5" : "R6";
    check("R9 out_valid", out_valid, 1);
    check("R1 class", {is_invalid, is_pointer, is_leaf}, exp_class(t));
    check({gtag, " granted"}, granted, exp_grant(t, ac, pv, mx, sm));
    check("R6 priv_error", priv_error, pv >= 2);
    check("R7 upd_needed", upd_needed, upd);
    check("R7 upd_attr", upd_attr, upd ? (t | 8'h40 | (upd_d ? 8'h80 : 8'h00)) : t);
    check("R8 cause", exc_cause, exp_cause(ac, fk));
    check("R9 ppn", ppn, pte[53:10]);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset out_valid", out_valid, 0);
    check("R10 reset results", {is_invalid, is_pointer, is_leaf, granted, upd_needed, upd_attr}, 0);
    rst_n = 1'b1;

    // directed R2: load with execute-only page and mxr, supervisor non-user page
    drive(8'b0100_1001, 2'd1, 2'd1, 1'b1, 1'b0, 3'd1);
    check("R2 exec-only load with mxr", granted, 1);
    drive(8'b0100_1001, 2'd1, 2'd1, 1'b0, 1'b0, 3'd1);
    check("R2 exec-only load without mxr", granted, 0);
    drive(8'b1100_0111, 2'd3, 2'd1, 1'b0, 1'b0, 3'd1);
    check("R2 atomic on read-write page", granted, 1);
    drive(8'b1100_0101, 2'd2, 2'd1, 1'b0, 1'b0, 3'd1);
    check("R2 write-no-read invalid entry class", is_invalid, 1);
    // directed R3: mxr has no effect on fetch
    drive(8'b0100_0011, 2'd0, 2'd1, 1'b1, 1'b0, 3'd0);
    check("R3 fetch on non-exec page with mxr", granted, 0);
    drive(8'b0100_1001, 2'd0, 2'd1, 1'b0, 1'b1, 3'd0);
    check("R3 fetch on exec page", granted, 1);

    for (int t = 0; t < 256; t++)
      for (int ac = 0; ac < 4; ac++)
        for (int pv = 0; pv < 4; pv++)
          for (int ms = 0; ms < 4; ms++)
            full_check(8'(t), 2'(ac), 2'(pv), ms[0], ms[1], 3'((t + ac) % 5));

    for (int ac = 0; ac < 4; ac++)
      for (int fk = 0; fk < 8; fk++)
        full_check(8'hCF, 2'(ac), 2'd1, 1'b0, 1'b0, 3'(fk));

    // R9: idle cycle drops out_valid one cycle later
    in_valid = 1'b0;
    @(posedge clk); #1;
    check("R9 out_valid after idle", out_valid, 0);
    full_check(8'h0F, 2'd1, 2'd0, 1'b0, 1'b0, 3'd2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule